// File: doc/BRIEF.md
# Banked Flash Query Responder

This block answers reads that a host makes while a parallel flash bank is in its query mode or its identification mode. The bank is assumed to be one or more identical devices placed side by side on the data bus, and the block forms the reply that the whole bank would drive. It turns the byte offset of the read into a table or ID index, looks up one device's reply, and copies that reply into every device lane of the bank.

Bank width, device width and the device's largest native width are elaboration parameters. A read may be wider than the bank. In that case the block joins several bank replies, one per bank-width step of the offset. The block holds the query table in a register array. The array is loaded at reset from the bank geometry: block count and total sector size.

Each read request gives its result one clock later, marked by a valid strobe. Byte lanes beyond the requested access width are forced to zero.

Top module: `flash_query_resp`

## Requirements
- R1: The lookup index is the read offset shifted right by log2(bank bytes) + log2(largest device bytes) - log2(device bytes).
- R2: In query mode (`rd_mode` = 0), an index of 82 (0x52) or more returns zero, including indices whose low bits would alias a valid entry.
- R3: A device used at a width below its native width returns its query byte in every byte lane, provided it is used byte-wide in a bank of at most 4 bytes. A device used at its native width returns the byte in the lowest byte of its lane, with zero padding above it.
- R4: The single-device reply is copied into every device-width lane across the bank width.
- R5: In ID mode (`rd_mode` = 1), only the low 8 bits of the index matter. Index 0 gives `mfr_id`, index 1 gives `dev_id`, and every other index (lock-status locations included) gives zero. Each is cut to the device width.
- R6: For a read wider than the bank, the bank reply for offset + k*bank bytes is placed at byte k*bank bytes of `rd_data`.
- R7: The table holds "QRY" (0x51 0x52 0x59) at indices 0x10-0x12, command set 0x0001 at 0x13-0x14, and "PRI10" (0x50 0x52 0x49 0x31 0x30) at 0x31-0x35.
- R8: The table holds the following values.
  - Index 0x2A: the log2 of the buffered-write size, which is 8 for a 1-byte bank and 11 otherwise.
  - Indices 0x2D-0x2E: blocks per device minus one, low byte first.
  - Indices 0x2F-0x30: the per-device sector size divided by 256, low byte first.
  - Index 0x27: the log2 of the device size.
- R9: `rd_valid` rises exactly one cycle after a cycle with `rd_en` high, and at no other time.
- R10: `rd_size` 0 returns 1 byte, 1 returns 2 bytes, and 2 or 3 returns 4 bytes. All bytes above the access width are zero.
- R11: After reset and in every cycle without a valid read, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads the query table |
| rd_en | input | 1 | Read request this cycle |
| rd_ofs | input | OFS_W | Byte offset of the read |
| rd_size | input | 2 | Access width code (R10) |
| rd_mode | input | 1 | 0 = query table, 1 = identification |
| mfr_id | input | 16 | Manufacturer ID word |
| dev_id | input | 16 | Device ID word |
| rd_valid | output | 1 | Reply present on `rd_data` |
| rd_data | output | 32 | Reply data, least significant byte at lowest offset |

## Verification
The bench drives two banks from the same stimulus. One is built from byte-wide parts that are natively 16 bits wide. The other is built from 16-bit parts used at full width. Each read is checked against values worked out from the requirements.

The padding-versus-repeat rule (R3) is visible only by comparing the two banks. A design that pads in both cases gives zero bytes in the narrow bank. A design that repeats in both cases gives copied bytes where the native bank should show zeros.

Indices past the table and ID indices above 0xFF target designs that truncate the index. Such a design would return aliased table or ID bytes where zero or the ID is expected.

Wide reads whose two halves fall on different entries catch a slot order that is swapped or not advanced. Reads of 1 and 2 bytes catch upper byte lanes that leak through.

// File: rtl/flash_query_pkg.sv
package flash_query_pkg;

    // Widest single access the block serves, in bytes.
    localparam int ACC_BYTES = 4;
    localparam int ACC_BITS  = ACC_BYTES * 8;

    // Depth of the query table and the index width needed to address it.
    localparam int TBL_LEN   = 82;
    localparam int TBL_IDX_W = $clog2(TBL_LEN);

    typedef enum logic {
        MODE_QUERY = 1'b0,
        MODE_IDENT = 1'b1
    } qmode_e;

    typedef struct packed {
        logic                valid;
        logic [ACC_BITS-1:0] data;
    } rd_state_t;

    // Bytes carried by an access width code; code 3 is served as 4 bytes.
    function automatic int size_bytes(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/flash_qtable.sv
module flash_qtable
    import flash_query_pkg::*;
#(
    parameter int BANK_BYTES   = 2,
    parameter int DEV_BYTES    = 1,
    parameter int BLOCK_COUNT  = 128,
    parameter int SECTOR_BYTES = 131072
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [TBL_LEN*8-1:0] tbl_q
);

    localparam int    NUM_DEV     = BANK_BYTES / DEV_BYTES;
    localparam int    SEC_PER_DEV = SECTOR_BYTES / NUM_DEV;
    localparam longint DEV_LEN    = longint'(SEC_PER_DEV) * longint'(BLOCK_COUNT);
    localparam int    DEV_LOG2    = $clog2(DEV_LEN);
    localparam int    BUF_LOG2    = (BANK_BYTES == 1) ? 8 : 11;
    localparam int    BLK_M1      = BLOCK_COUNT - 1;

    function automatic logic [TBL_LEN*8-1:0] build_table();
        logic [TBL_LEN*8-1:0] t;
        t = '0;
        // signature
        t[8*'h10 +: 8] = 8'h51;
        t[8*'h11 +: 8] = 8'h52;
        t[8*'h12 +: 8] = 8'h59;
        // command set and extended table pointer
        t[8*'h13 +: 8] = 8'h01;
        t[8*'h14 +: 8] = 8'h00;
        t[8*'h15 +: 8] = 8'h31;
        // supply range and timing hints
        t[8*'h1B +: 8] = 8'h45;
        t[8*'h1C +: 8] = 8'h55;
        t[8*'h1F +: 8] = 8'h07;
        t[8*'h20 +: 8] = 8'h07;
        t[8*'h21 +: 8] = 8'h0A;
        t[8*'h23 +: 8] = 8'h04;
        t[8*'h24 +: 8] = 8'h04;
        t[8*'h25 +: 8] = 8'h04;
        // geometry
        t[8*'h27 +: 8] = 8'(DEV_LOG2);
        t[8*'h28 +: 8] = 8'h02;
        t[8*'h2A +: 8] = 8'(BUF_LOG2);
        t[8*'h2C +: 8] = 8'h01;
        t[8*'h2D +: 8] = 8'(BLK_M1);
        t[8*'h2E +: 8] = 8'(BLK_M1 >> 8);
        t[8*'h2F +: 8] = 8'(SEC_PER_DEV >> 8);
        t[8*'h30 +: 8] = 8'(SEC_PER_DEV >> 16);
        // extended block signature and version
        t[8*'h31 +: 8] = 8'h50;
        t[8*'h32 +: 8] = 8'h52;
        t[8*'h33 +: 8] = 8'h49;
        t[8*'h34 +: 8] = 8'h31;
        t[8*'h35 +: 8] = 8'h30;
        t[8*'h3F +: 8] = 8'h01;
        return t;
    endfunction

    localparam logic [TBL_LEN*8-1:0] TBL_INIT = build_table();

    logic [TBL_LEN*8-1:0] tbl_d;

    always_comb begin
        tbl_d = tbl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= TBL_INIT;
        else        tbl_q <= tbl_d;
    end

endmodule

// File: rtl/flash_bank_reply.sv
module flash_bank_reply
    import flash_query_pkg::*;
#(
    parameter int BANK_BYTES    = 2,
    parameter int DEV_BYTES     = 1,
    parameter int DEV_MAX_BYTES = 2,
    parameter int OFS_W         = 12
) (
    input  logic [OFS_W-1:0]        ofs,
    input  logic                    mode,
    input  logic [15:0]             mfr_id,
    input  logic [15:0]             dev_id,
    input  logic [TBL_LEN*8-1:0]    tbl,
    output logic [BANK_BYTES*8-1:0] reply
);

    localparam int SHIFT   = $clog2(BANK_BYTES) + $clog2(DEV_MAX_BYTES) - $clog2(DEV_BYTES);
    localparam bit NARROW  = DEV_BYTES < DEV_MAX_BYTES;
    localparam bit X8_OK   = (DEV_BYTES == 1) && (BANK_BYTES <= 4);
    localparam bit Q_LIVE  = !NARROW || X8_OK;
    localparam int LANES   = BANK_BYTES / DEV_BYTES;
    localparam int DBITS   = DEV_BYTES * 8;

    logic [OFS_W-1:0] idx;
    logic             in_range;
    logic [7:0]       qbyte;
    logic [31:0]      ident;
    logic [DBITS-1:0] qword;
    logic [DBITS-1:0] dword;

    always_comb begin
        idx      = ofs >> SHIFT;
        in_range = idx < OFS_W'(TBL_LEN);
        qbyte    = in_range ? tbl[{idx[TBL_IDX_W-1:0], 3'b000} +: 8] : 8'h00;

        qword        = '0;
        qword[7:0]   = Q_LIVE ? qbyte : 8'h00;

        ident = 32'h0;
        case (idx[7:0])
            8'd0:    ident = {16'h0, mfr_id};
            8'd1:    ident = {16'h0, dev_id};
            default: ident = 32'h0;
        endcase

        dword = (qmode_e'(mode) == MODE_IDENT) ? ident[DBITS-1:0] : qword;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign reply[l*DBITS +: DBITS] = dword;
    end

endmodule

// File: rtl/flash_query_resp.sv
module flash_query_resp
    import flash_query_pkg::*;
#(
    parameter int BANK_BYTES    = 2,
    parameter int DEV_BYTES     = 1,
    parameter int DEV_MAX_BYTES = 2,
    parameter int OFS_W         = 12,
    parameter int BLOCK_COUNT   = 128,
    parameter int SECTOR_BYTES  = 131072
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [OFS_W-1:0]    rd_ofs,
    input  logic [1:0]          rd_size,
    input  logic                rd_mode,
    input  logic [15:0]         mfr_id,
    input  logic [15:0]         dev_id,
    output logic                rd_valid,
    output logic [ACC_BITS-1:0] rd_data
);

    localparam int NSLOT = (BANK_BYTES >= ACC_BYTES) ? 1 : ACC_BYTES / BANK_BYTES;
    localparam int SBITS = BANK_BYTES * 8;

    // Elaboration guards on the width parameters.
    function automatic bit legal_width(int w);
        return (w == 1) || (w == 2) || (w == 4);
    endfunction

    if (!legal_width(BANK_BYTES) || !legal_width(DEV_BYTES) || !legal_width(DEV_MAX_BYTES)) begin : g_bad_width
        $error("flash_query_resp: widths must be 1, 2 or 4 bytes");
    end
    if (DEV_BYTES > BANK_BYTES || DEV_BYTES > DEV_MAX_BYTES) begin : g_bad_ratio
        $error("flash_query_resp: device width exceeds bank or native width");
    end
    if (OFS_W < 8) begin : g_bad_ofs
        $error("flash_query_resp: offset must be at least 8 bits");
    end

    logic [TBL_LEN*8-1:0] tbl;
    logic [ACC_BITS-1:0]  joined;
    logic [ACC_BITS-1:0]  lane_mask;
    rd_state_t            st_d, st_q;

    flash_qtable #(
        .BANK_BYTES  (BANK_BYTES),
        .DEV_BYTES   (DEV_BYTES),
        .BLOCK_COUNT (BLOCK_COUNT),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_qtable (
        .clk  (clk),
        .rst_n(rst_n),
        .tbl_q(tbl)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [OFS_W-1:0] slot_ofs;
        logic [SBITS-1:0] slot_reply;

        assign slot_ofs = rd_ofs + OFS_W'(s * BANK_BYTES);

        flash_bank_reply #(
            .BANK_BYTES   (BANK_BYTES),
            .DEV_BYTES    (DEV_BYTES),
            .DEV_MAX_BYTES(DEV_MAX_BYTES),
            .OFS_W        (OFS_W)
        ) u_reply (
            .ofs   (slot_ofs),
            .mode  (rd_mode),
            .mfr_id(mfr_id),
            .dev_id(dev_id),
            .tbl   (tbl),
            .reply (slot_reply)
        );

        if (SBITS >= ACC_BITS) begin : g_full
            assign joined[s*ACC_BITS +: ACC_BITS] = slot_reply[ACC_BITS-1:0];
        end else begin : g_part
            assign joined[s*SBITS +: SBITS] = slot_reply;
        end
    end

    always_comb begin
        lane_mask = '0;
        for (int b = 0; b < ACC_BYTES; b++) begin
            if (b < size_bytes(rd_size)) lane_mask[b*8 +: 8] = 8'hFF;
        end
        st_d.valid = rd_en;
        st_d.data  = rd_en ? (joined & lane_mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

endmodule

// File: rtl/flash_query_resp_chk.sv
module flash_query_resp_chk
    import flash_query_pkg::*;
#(
    parameter int BANK_BYTES = 2,
    parameter int DEV_BYTES  = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [1:0]          rd_size,
    input logic                rd_valid,
    input logic [ACC_BITS-1:0] rd_data
);

    localparam int DBITS = DEV_BYTES * 8;

    p_valid_after_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    p_byte_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size == 2'd0) |=> (rd_data[ACC_BITS-1:8] == '0));

    p_half_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size == 2'd1) |=> (rd_data[ACC_BITS-1:16] == '0));

    if (BANK_BYTES >= 2 * DEV_BYTES) begin : g_copy
        p_lane_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && size_bytes(rd_size) >= 2 * DEV_BYTES)
            |=> (rd_data[DBITS +: DBITS] == rd_data[0 +: DBITS]));
    end

endmodule

bind flash_query_resp flash_query_resp_chk #(
    .BANK_BYTES(BANK_BYTES),
    .DEV_BYTES (DEV_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_size (rd_size),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
);

// File: tb/test_flash_query_resp.sv
module test_flash_query_resp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_ofs = '0;
    logic [1:0]  rd_size = '0;
    logic        rd_mode = 1'b0;
    logic [15:0] mfr_id = 16'h1289;
    logic [15:0] dev_id = 16'hAB34;

    logic        va, vb;
    logic [31:0] da, db;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    // Narrow bank: two byte-wide devices that are natively 16 bits (index shift 2).
    flash_query_resp #(
        .BANK_BYTES(2), .DEV_BYTES(1), .DEV_MAX_BYTES(2), .OFS_W(12),
        .BLOCK_COUNT(128), .SECTOR_BYTES(131072)
    ) i_flash_query_resp (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ofs(rd_ofs),
        .rd_size(rd_size), .rd_mode(rd_mode), .mfr_id(mfr_id), .dev_id(dev_id),
        .rd_valid(va), .rd_data(da)
    );

    // Native bank: two 16-bit devices at full width (index shift 2).
    flash_query_resp #(
        .BANK_BYTES(4), .DEV_BYTES(2), .DEV_MAX_BYTES(2), .OFS_W(12),
        .BLOCK_COUNT(128), .SECTOR_BYTES(131072)
    ) i_flash_query_resp_native (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ofs(rd_ofs),
        .rd_size(rd_size), .rd_mode(rd_mode), .mfr_id(mfr_id), .dev_id(dev_id),
        .rd_valid(vb), .rd_data(db)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
        end
    endtask

    // One read on both banks; result sampled one cycle after the request.
    task automatic do_read(string req, logic mode, logic [11:0] ofs, logic [1:0] sz,
                           logic [31:0] exp_a, logic [31:0] exp_b);
        @(negedge clk);
        rd_en = 1'b1; rd_mode = mode; rd_ofs = ofs; rd_size = sz;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check("R9", "narrow valid", {31'b0, va}, 32'd1);
        check(req, $sformatf("narrow ofs %03h", ofs), da, exp_a);
        check(req, $sformatf("native ofs %03h", ofs), db, exp_b);
    endtask

    task automatic t_reset;
        check("R11", "valid in reset", {31'b0, va}, 32'd0);
        check("R11", "data in reset", da, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R11", "valid after reset", {31'b0, va | vb}, 32'd0);
        check("R11", "data after reset", da | db, 32'd0);
    endtask

    task automatic t_signature;
        // R7 / R1: 'Q' at index 0x10 = offset 0x40; R3 narrow repeats, native pads
        do_read("R3", 1'b0, 12'h040, 2'd1, 32'h0000_5151, 32'h0000_0051);
        do_read("R4", 1'b0, 12'h040, 2'd2, 32'h5151_5151, 32'h0051_0051);
        // R6: halves at different indices ('R' then 'Y')
        do_read("R6", 1'b0, 12'h046, 2'd2, 32'h5959_5252, 32'h0052_0052);
        do_read("R7", 1'b0, 12'h04C, 2'd2, 32'h0101_0101, 32'h0001_0001);
        do_read("R7", 1'b0, 12'h0CE, 2'd2, 32'h3131_4949, 32'h0049_0049);
        do_read("R7", 1'b0, 12'h0D4, 2'd1, 32'h0000_3030, 32'h0000_0030);
        do_read("R1", 1'b0, 12'h054, 2'd0, 32'h0000_0031, 32'h0000_0031);
    endtask

    task automatic t_geometry;
        do_read("R8", 1'b0, 12'h0A8, 2'd1, 32'h0000_0B0B, 32'h0000_000B);
        do_read("R8", 1'b0, 12'h09C, 2'd1, 32'h0000_1717, 32'h0000_0017);
        do_read("R8", 1'b0, 12'h0B4, 2'd1, 32'h0000_7F7F, 32'h0000_007F);
        do_read("R8", 1'b0, 12'h0B8, 2'd1, 32'h0000_0000, 32'h0000_0000);
        do_read("R8", 1'b0, 12'h0C0, 2'd1, 32'h0000_0101, 32'h0000_0001);
    endtask

    task automatic t_range;
        do_read("R2", 1'b0, 12'h148, 2'd2, 32'h0, 32'h0);
        do_read("R2", 1'b0, 12'h440, 2'd2, 32'h0, 32'h0);
        do_read("R2", 1'b0, 12'h840, 2'd2, 32'h0, 32'h0);
    endtask

    task automatic t_ident;
        do_read("R5", 1'b1, 12'h000, 2'd2, 32'h8989_8989, 32'h1289_1289);
        do_read("R6", 1'b1, 12'h002, 2'd2, 32'h3434_8989, 32'h1289_1289);
        do_read("R5", 1'b1, 12'h004, 2'd1, 32'h0000_3434, 32'h0000_AB34);
        do_read("R5", 1'b1, 12'h008, 2'd2, 32'h0, 32'h0);
        do_read("R5", 1'b1, 12'h00C, 2'd2, 32'h0, 32'h0);
        do_read("R5", 1'b1, 12'h400, 2'd2, 32'h8989_8989, 32'h1289_1289);
        do_read("R5", 1'b1, 12'h404, 2'd1, 32'h0000_3434, 32'h0000_AB34);
        mfr_id = 16'h00C7; dev_id = 16'h0018;
        do_read("R5", 1'b1, 12'h000, 2'd2, 32'hC7C7_C7C7, 32'h00C7_00C7);
        do_read("R5", 1'b1, 12'h004, 2'd2, 32'h1818_1818, 32'h0018_0018);
        mfr_id = 16'h1289; dev_id = 16'hAB34;
    endtask

    task automatic t_size;
        do_read("R10", 1'b1, 12'h000, 2'd0, 32'h0000_0089, 32'h0000_0089);
        do_read("R10", 1'b1, 12'h000, 2'd3, 32'h8989_8989, 32'h1289_1289);
        do_read("R10", 1'b0, 12'h046, 2'd0, 32'h0000_0052, 32'h0000_0052);
    endtask

    task automatic t_idle;
        do_read("R9", 1'b0, 12'h040, 2'd2, 32'h5151_5151, 32'h0051_0051);
        @(negedge clk);
        check("R9", "valid drops", {31'b0, va | vb}, 32'd0);
        check("R11", "data idle", da | db, 32'd0);
    endtask

    initial begin
        t_reset();
        t_signature();
        t_geometry();
        t_range();
        t_ident();
        t_size();
        t_idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule